// File: doc/BRIEF.md
# Touch Confirmation Integrator with Per-Key Recalibration Timers

This block sits after the per-key signal comparators of a ten-key capacitive sensor. It turns raw per-burst "signal above threshold" flags into debounced touched or released states. A touch is confirmed only after a run of agreeing samples, and a release is confirmed the same way. The run lengths are asymmetric, and they are shorter in fast mode. Any sample that disagrees with the run restarts the count.

The keys are measured in three burst groups, each with its own strobe. A key's counter advances only on the strobe of its own group. Each key also has two timers that count millisecond ticks. The first is a maximum-on timer, active while the key is confirmed touched. The second is an anti-detect timer, active while the key's capacitance-decrease flag is high. When either timer expires, that key alone gets a one-cycle recalibrate pulse, and it is forced back to released with its counters and timers cleared. A detect output reports whether any key is touched, in a polarity the integrator selects.

Top module: `touch_integrator`

## Requirements
- R1: In normal mode (`fast_mode`=0), a released key becomes touched in the cycle after the 6th consecutive strobe of its group that samples its `above_thr` bit high.
- R2: In normal mode, a touched key becomes released in the cycle after the 3rd consecutive strobe of its group that samples its `above_thr` bit low.
- R3: In fast mode (`fast_mode`=1), a touch needs 3 consecutive agreeing strobes and a release needs 2.
- R4: A strobe that samples the opposite level clears the key's run count, so a full new run is needed.
- R5: `burst_strobe[0]` samples keys 0, 1, 4 and 5. `burst_strobe[1]` samples keys 2, 3, 6 and 7. `burst_strobe[2]` samples keys 8 and 9. A key ignores samples taken without its own group strobe.
- R6: `hold_sel` sets the maximum-on limit: 2'b01 gives HOLD_SHORT_MS ticks, 2'b10 gives HOLD_LONG_MS ticks, and 2'b00 or 2'b11 gives no limit. The `ms_tick` that completes the limit for a touched key raises that key's `recal_pulse` bit for one cycle, in the same cycle as its state returns to released.
- R7: When a key's `anti_flag` stays high for ANTI_MS consecutive `ms_tick`s, that key gets a one-cycle `recal_pulse` and becomes released. A low `anti_flag` restarts that count.
- R8: A recalibration pulses and releases only the key whose timer expired. Other keys keep their state and timers.
- R9: After a recalibration, the key needs a full new confirmation run before it is touched again.
- R10: `detect_out` is the OR of all `key_state` bits when `detect_high`=1, and its inverse when `detect_high`=0.
- R11: After reset, all keys are released, no `recal_pulse` bit is set, and `detect_out` is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_strobe | input | NUM_GROUPS | One-cycle strobe per burst group; samples that group's flags |
| above_thr | input | NUM_KEYS | Per-key flag: signal above the touch threshold |
| anti_flag | input | NUM_KEYS | Per-key flag: large capacitance decrease seen |
| fast_mode | input | 1 | 1 selects the short confirmation runs |
| hold_sel | input | 2 | Maximum-on limit select |
| detect_high | input | 1 | 1 makes detect_out active high |
| ms_tick | input | 1 | One-cycle millisecond tick |
| key_state | output | NUM_KEYS | Confirmed touched state per key |
| recal_pulse | output | NUM_KEYS | One-cycle recalibrate request per key |
| detect_out | output | 1 | Any key touched, in the selected polarity |

## Verification
The hardest case to reach from the ports is a maximum-on expiry for one key while another key is touched partway through its own timer. The stimulus starts a touch, lets some ticks pass, and then confirms a second key in the same burst group. The first key's pulse must then leave the second key touched, and the second key must expire later after exactly its own tick count. The two other hard cases are a run broken one sample short, and an anti-detect count interrupted one tick short. Both are built from directed strobes and ticks that stop exactly at the boundary.

// File: rtl/touchint_pkg.sv
package touchint_pkg;

  typedef enum logic [1:0] {
    HOLD_NONE  = 2'b00,
    HOLD_SHORT = 2'b01,
    HOLD_LONG  = 2'b10,
    HOLD_NONE2 = 2'b11
  } hold_sel_e;

  // burst group that measures key k: 8,9 -> 2; pairs alternate 0/1 below that
  function automatic int unsigned group_of(input int unsigned k);
    if (k >= 8) return 2;
    return (k >> 1) & 1;
  endfunction

  // run length required to change state
  function automatic int unsigned run_needed(input logic touched, input logic fast,
                                             input int unsigned t_norm, input int unsigned r_norm,
                                             input int unsigned t_fast, input int unsigned r_fast);
    if (fast) return touched ? r_fast : t_fast;
    return touched ? r_norm : t_norm;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/key_integrator.sv
module key_integrator #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             above,
  input  logic [CNT_W-1:0] need_touch,
  input  logic [CNT_W-1:0] need_rel,
  input  logic             clear,
  output logic             state_o,
  output logic             touch_ev,
  output logic             rel_ev
);
  logic             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;
  logic [CNT_W-1:0] need;
  logic             agree;
  logic             reached;

  always_comb begin
    agree   = state_q ? !above : above;
    cnt_nxt = {1'b0, cnt_q} + 1'b1;
    need    = state_q ? need_rel : need_touch;
    reached = sample_en && agree && (cnt_nxt >= {1'b0, need});
  end

  assign touch_ev = reached && !state_q;
  assign rel_ev   = reached && state_q;
  assign state_o  = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sample_en) begin
      if (!agree) begin
        cnt_q <= '0;
      end else if (reached) begin
        state_q <= !state_q;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_nxt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/key_recal_timer.sv
module key_recal_timer #(
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned ANTI_MS = 2000,
  parameter int unsigned ANTI_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             touched,
  input  logic             anti,
  input  logic [TMR_W-1:0] hold_limit,
  output logic             fire
);
  logic [TMR_W-1:0]  on_q;
  logic [ANTI_W-1:0] anti_q;
  logic              hold_on;
  logic              on_fire;
  logic              anti_fire;

  localparam logic [ANTI_W-1:0] ANTI_LAST = ANTI_W'(ANTI_MS - 1);

  always_comb begin
    hold_on   = touched && (hold_limit != '0);
    on_fire   = tick && hold_on && (on_q >= hold_limit - 1'b1);
    anti_fire = tick && anti && (anti_q >= ANTI_LAST);
  end

  assign fire = on_fire || anti_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= '0;
      anti_q <= '0;
    end else if (fire) begin
      on_q   <= '0;
      anti_q <= '0;
    end else begin
      if (!hold_on)  on_q <= '0;
      else if (tick) on_q <= on_q + 1'b1;
      if (!anti)     anti_q <= '0;
      else if (tick) anti_q <= anti_q + 1'b1;
    end
  end
endmodule

// File: rtl/detect_merge.sv
module detect_merge #(
  parameter int unsigned NUM_KEYS = 10
) (
  input  logic [NUM_KEYS-1:0] states,
  input  logic                active_high,
  output logic                detect_o
);
  logic any_on;
  assign any_on   = |states;
  assign detect_o = active_high ? any_on : !any_on;
endmodule

// File: rtl/touch_integrator.sv
module touch_integrator
  import touchint_pkg::*;
#(
  parameter int unsigned NUM_KEYS      = 10,
  parameter int unsigned NUM_GROUPS    = 3,
  parameter int unsigned TOUCH_NORM    = 6,
  parameter int unsigned REL_NORM      = 3,
  parameter int unsigned TOUCH_FAST    = 3,
  parameter int unsigned REL_FAST      = 2,
  parameter int unsigned HOLD_SHORT_MS = 10000,
  parameter int unsigned HOLD_LONG_MS  = 60000,
  parameter int unsigned ANTI_MS       = 2000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] burst_strobe,
  input  logic [NUM_KEYS-1:0]   above_thr,
  input  logic [NUM_KEYS-1:0]   anti_flag,
  input  logic                  fast_mode,
  input  logic [1:0]            hold_sel,
  input  logic                  detect_high,
  input  logic                  ms_tick,
  output logic [NUM_KEYS-1:0]   key_state,
  output logic [NUM_KEYS-1:0]   recal_pulse,
  output logic                  detect_out
);
  localparam int unsigned RUN_MAX = max2(max2(TOUCH_NORM, REL_NORM), max2(TOUCH_FAST, REL_FAST));
  localparam int unsigned CNT_W   = $clog2(RUN_MAX + 1);
  localparam int unsigned TMR_W   = $clog2(max2(HOLD_SHORT_MS, HOLD_LONG_MS) + 1);
  localparam int unsigned ANTI_W  = $clog2(ANTI_MS + 1);

  // named internal events, observed by the bound checker
  logic [NUM_KEYS-1:0] touch_ev;
  logic [NUM_KEYS-1:0] rel_ev;
  logic [NUM_KEYS-1:0] recal_req;
  logic [NUM_KEYS-1:0] sample_en;

  logic [CNT_W-1:0] need_touch;
  logic [CNT_W-1:0] need_rel;
  logic [TMR_W-1:0] hold_limit;

  always_comb begin
    need_touch = CNT_W'(run_needed(1'b0, fast_mode, TOUCH_NORM, REL_NORM, TOUCH_FAST, REL_FAST));
    need_rel   = CNT_W'(run_needed(1'b1, fast_mode, TOUCH_NORM, REL_NORM, TOUCH_FAST, REL_FAST));
    case (hold_sel_e'(hold_sel))
      HOLD_SHORT: hold_limit = TMR_W'(HOLD_SHORT_MS);
      HOLD_LONG:  hold_limit = TMR_W'(HOLD_LONG_MS);
      default:    hold_limit = '0;
    endcase
  end

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam int unsigned GRP = group_of(k);

    assign sample_en[k] = burst_strobe[GRP];

    key_integrator #(.CNT_W(CNT_W)) i_integ (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en[k]),
      .above      (above_thr[k]),
      .need_touch (need_touch),
      .need_rel   (need_rel),
      .clear      (recal_req[k]),
      .state_o    (key_state[k]),
      .touch_ev   (touch_ev[k]),
      .rel_ev     (rel_ev[k])
    );

    key_recal_timer #(.TMR_W(TMR_W), .ANTI_MS(ANTI_MS), .ANTI_W(ANTI_W)) i_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (ms_tick),
      .touched    (key_state[k]),
      .anti       (anti_flag[k]),
      .hold_limit (hold_limit),
      .fire       (recal_req[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recal_pulse <= '0;
    else        recal_pulse <= recal_req;
  end

  detect_merge #(.NUM_KEYS(NUM_KEYS)) i_detect (
    .states      (key_state),
    .active_high (detect_high),
    .detect_o    (detect_out)
  );
endmodule

// File: rtl/touchint_chk.sv
module touchint_chk #(
  parameter int unsigned NUM_KEYS   = 10,
  parameter int unsigned NUM_GROUPS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_GROUPS-1:0] burst_strobe,
  input logic                  ms_tick,
  input logic                  detect_high,
  input logic                  detect_out,
  input logic [NUM_KEYS-1:0]   key_state,
  input logic [NUM_KEYS-1:0]   recal_pulse,
  input logic [NUM_KEYS-1:0]   touch_ev,
  input logic [NUM_KEYS-1:0]   rel_ev,
  input logic [NUM_KEYS-1:0]   recal_req
);
  p_touch_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    |(touch_ev & ~recal_req) |=>
      ((key_state & $past(touch_ev & ~recal_req)) == $past(touch_ev & ~recal_req)));

  p_change_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (key_state != $past(key_state)) |-> $past(|(touch_ev | rel_ev | recal_req)));

  p_sample_needs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |(touch_ev | rel_ev) |-> |burst_strobe);

  p_recal_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (recal_pulse & key_state) == '0);

  p_recal_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |recal_pulse |-> $past(ms_tick));

  p_recal_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    |recal_pulse |=> ((recal_pulse & $past(recal_pulse)) == '0));

  p_idle_detect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_state == '0) |-> (detect_out != detect_high));
endmodule

bind touch_integrator touchint_chk #(.NUM_KEYS(NUM_KEYS), .NUM_GROUPS(NUM_GROUPS)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .burst_strobe (burst_strobe),
  .ms_tick      (ms_tick),
  .detect_high  (detect_high),
  .detect_out   (detect_out),
  .key_state    (key_state),
  .recal_pulse  (recal_pulse),
  .touch_ev     (touch_ev),
  .rel_ev       (rel_ev),
  .recal_req    (recal_req)
);

// File: tb/test_touch_integrator.sv
module test_touch_integrator;
  localparam int NK    = 10;
  localparam int SHORT = 8;
  localparam int LONG  = 20;
  localparam int ANTI  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    burst_strobe = '0;
  logic [NK-1:0] above_thr = '0;
  logic [NK-1:0] anti_flag = '0;
  logic          fast_mode = 1'b0;
  logic [1:0]    hold_sel = 2'b00;
  logic          detect_high = 1'b1;
  logic          ms_tick = 1'b0;
  logic [NK-1:0] key_state;
  logic [NK-1:0] recal_pulse;
  logic          detect_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [NK-1:0] seen_recal;

  always #2 clk = ~clk;

  touch_integrator #(
    .HOLD_SHORT_MS(SHORT), .HOLD_LONG_MS(LONG), .ANTI_MS(ANTI)
  ) i_touch_integrator (
    .clk(clk), .rst_n(rst_n), .burst_strobe(burst_strobe), .above_thr(above_thr),
    .anti_flag(anti_flag), .fast_mode(fast_mode), .hold_sel(hold_sel),
    .detect_high(detect_high), .ms_tick(ms_tick), .key_state(key_state),
    .recal_pulse(recal_pulse), .detect_out(detect_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [NK-1:0] exp);
    check(key_state == exp, req, 32'(key_state), 32'(exp));
  endtask

  task automatic strobe(input logic [2:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) burst_strobe = mask;
      @(negedge clk) burst_strobe = '0;
    end
  endtask

  task automatic ticks(input int n);
    seen_recal = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) begin
        ms_tick = 1'b0;
        seen_recal |= recal_pulse;
      end
    end
  endtask

  task automatic release_all();
    above_thr = '0;
    anti_flag = '0;
    fast_mode = 1'b0;
    strobe(3'b111, 3);
  endtask

  task automatic t_reset();
    check_state("R11 state", '0);
    check(recal_pulse == '0, "R11 recal", 32'(recal_pulse), 0);
    check(detect_out == 1'b0, "R11 detect", 32'(detect_out), 0);
  endtask

  task automatic t_normal();
    above_thr = NK'(1) << 0;
    strobe(3'b001, 5);
    check_state("R1 five samples", '0);
    strobe(3'b001, 1);
    check_state("R1 sixth sample", NK'(1));
    check(detect_out == 1'b1, "R10 detect high", 32'(detect_out), 1);
    above_thr = '0;
    strobe(3'b001, 2);
    check_state("R2 two lows", NK'(1));
    strobe(3'b001, 1);
    check_state("R2 third low", '0);
  endtask

  task automatic t_break();
    above_thr = NK'(1) << 2;
    strobe(3'b010, 4);
    above_thr = '0;
    strobe(3'b010, 1);
    above_thr = NK'(1) << 2;
    strobe(3'b010, 5);
    check_state("R4 broken run", '0);
    strobe(3'b010, 1);
    check_state("R4 full run", NK'(1) << 2);
    release_all();
  endtask

  task automatic t_group();
    above_thr = NK'(1) << 8;
    strobe(3'b011, 8);
    check_state("R5 foreign strobes", '0);
    strobe(3'b100, 6);
    check_state("R5 own strobe", NK'(1) << 8);
    release_all();
  endtask

  task automatic t_fast();
    fast_mode = 1'b1;
    above_thr = NK'(1) << 3;
    strobe(3'b010, 2);
    check_state("R3 two fast", '0);
    strobe(3'b010, 1);
    check_state("R3 third fast", NK'(1) << 3);
    above_thr = '0;
    strobe(3'b010, 1);
    check_state("R3 one release", NK'(1) << 3);
    strobe(3'b010, 1);
    check_state("R3 second release", '0);
    fast_mode = 1'b0;
  endtask

  task automatic t_maxon_short();
    hold_sel  = 2'b01;
    above_thr = NK'(1) << 5;
    strobe(3'b001, 6);
    ticks(3);
    above_thr = (NK'(1) << 5) | (NK'(1) << 1);
    strobe(3'b001, 6);
    check_state("R6 both touched", (NK'(1) << 5) | (NK'(1) << 1));
    ticks(4);
    check(seen_recal == '0, "R6 before limit", 32'(seen_recal), 0);
    ticks(1);
    check(seen_recal == NK'(1) << 5, "R8 only key5 recal", 32'(seen_recal), 32'(NK'(1) << 5));
    check_state("R8 key1 kept", NK'(1) << 1);
    strobe(3'b001, 5);
    check_state("R9 rerun short", NK'(1) << 1);
    strobe(3'b001, 1);
    check_state("R9 rerun full", (NK'(1) << 5) | (NK'(1) << 1));
    hold_sel = 2'b00;
    release_all();
  endtask

  task automatic t_maxon_long();
    hold_sel  = 2'b10;
    above_thr = NK'(1) << 7;
    strobe(3'b010, 6);
    ticks(LONG - 1);
    check(seen_recal == '0, "R6 long before limit", 32'(seen_recal), 0);
    ticks(1);
    check(seen_recal == NK'(1) << 7, "R6 long limit", 32'(seen_recal), 32'(NK'(1) << 7));
    check_state("R6 released", '0);
    hold_sel = 2'b00;
    strobe(3'b010, 6);
    ticks(LONG + 10);
    check(seen_recal == '0, "R6 no limit", 32'(seen_recal), 0);
    check_state("R6 still on", NK'(1) << 7);
    release_all();
  endtask

  task automatic t_anti();
    above_thr = NK'(1) << 6;
    strobe(3'b010, 6);
    above_thr = '0;
    anti_flag = NK'(1) << 6;
    ticks(ANTI - 1);
    anti_flag = '0;
    ticks(1);
    anti_flag = NK'(1) << 6;
    ticks(ANTI - 1);
    check(seen_recal == '0, "R7 restarted count", 32'(seen_recal), 0);
    check_state("R7 still touched", NK'(1) << 6);
    ticks(1);
    check(seen_recal == NK'(1) << 6, "R7 anti expiry", 32'(seen_recal), 32'(NK'(1) << 6));
    check_state("R7 released", '0);
    anti_flag = '0;
  endtask

  task automatic t_polarity();
    detect_high = 1'b0;
    @(negedge clk);
    check(detect_out == 1'b1, "R10 low idle", 32'(detect_out), 1);
    above_thr = NK'(1) << 9;
    strobe(3'b100, 6);
    check(detect_out == 1'b0, "R10 low active", 32'(detect_out), 0);
    release_all();
    detect_high = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_break();
    t_group();
    t_fast();
    t_maxon_short();
    t_maxon_long();
    t_anti();
    t_polarity();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule